// File: doc/BRIEF.md
# Prioritized CPU Interrupt Controller

This block gathers the interrupt sources of a processor core and decides which one the core should service next. Index 0 is a reset line (active-low), index 1 is a non-maskable interrupt, and indices 4 to 15 are twelve maskable lines. Indices 2 and 3 are unused. Each active-high line is turned into a pending flag on its rising edge. Software can also raise or drop maskable flags through write-one set and clear vectors. An enable register holds one enable per maskable line plus the NMI enable, and a separate global enable gates all maskable servicing.

The block presents a take request with the winning interrupt number to the core. When the core acknowledges the take, the block clears that flag and the global enable, and for an NMI it also clears the NMI enable. One cycle later it pulses an acknowledge strobe with the 4-bit number of the serviced interrupt. The reset line takes effect only after it has been held low for a set number of cycles. It then returns the block to its defaults and reports number 0 on the acknowledge outputs.

Top module: `irq_prio_ctl`

## Requirements
- R1: After power-on reset (`por_n` low), `flags_o`, `ena_o`, `gie_o`, `take_req` and `iack` are all 0.
- R2: A 0-to-1 transition on `nmi_line` sets flag bit 1, and one on `irq_line[k]` sets flag bit k+4, in the next cycle. A line held high does not set a flag again after it has been cleared.
- R3: A 1 in bit n (4..15) of `set_bits` sets flag n, and a 1 in bit n of `clr_bits` clears it. Zeros have no effect, and bits 0 to 3 of either vector never change any flag.
- R4: When `set_bits` and `clr_bits` both have a 1 in the same bit in the same cycle, the flag ends up set.
- R5: Flag n (4..15) produces a request only when all four of these are 1: `gie_o`, `ena_o[1]` (NMI enable), `ena_o[n]` and `flags_o[n]`.
- R6: Among the maskable interrupts that qualify, the lowest-numbered one is presented on `take_num`.
- R7: A pending NMI is requested whenever `ena_o[1]` is 1, regardless of `gie_o`. While it qualifies, it wins over every maskable interrupt.
- R8: `take_ack` high while `take_req` is high does the following at the next edge. It clears the chosen flag and `gie_o`, and for number 1 it also clears `ena_o[1]`. It also drives `iack` high for exactly one cycle, with `inum` equal to the taken number (bit 3 is the MSB, so 4'b1011 means interrupt 11).
- R9: `rst_line_n` held low for 10 consecutive cycles clears all flags, enables and `gie_o`, and pulses `iack` with `inum` = 0. A low pulse of 9 cycles changes nothing.
- R10: `take_ack` with no request pending produces no `iack` and changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_line_n | input | 1 | Reset interrupt line, active low, filtered by hold time |
| nmi_line | input | 1 | Non-maskable interrupt line, active high |
| irq_line | input | 12 | Maskable lines; bit k is interrupt k+4 |
| set_bits | input | 16 | Write-one flag set vector |
| clr_bits | input | 16 | Write-one flag clear vector |
| ena_we | input | 1 | Enable register write strobe |
| ena_wdata | input | 16 | Enable register data; bit 1 is NMI enable, bits 4..15 per line |
| gie_we | input | 1 | Global enable write strobe |
| gie_wdata | input | 1 | Global enable data |
| take_ack | input | 1 | Core accepts the presented interrupt |
| take_req | output | 1 | An interrupt qualifies for servicing |
| take_num | output | 4 | Number of the qualifying interrupt |
| iack | output | 1 | One-cycle acknowledge strobe |
| inum | output | 4 | Number of the interrupt being acknowledged |
| flags_o | output | 16 | Pending flags |
| ena_o | output | 16 | Enable register |
| gie_o | output | 1 | Global enable |

## Verification
The bench builds the block with its default parameters: sixteen indices, maskable lines starting at 4, and a 10-cycle reset hold. At these sizes every maskable line can be swept on its own, and every one of the sixteen combinations of the four servicing conditions can be tried. Forty pseudo-random flag and enable patterns check the lowest-number choice and the effects of each acknowledged take. The reset hold is short enough to try both the 9-cycle and the 10-cycle pulse.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
   localparam int unsigned IDX_RESET = 0;
   localparam int unsigned IDX_NMI   = 1;

   function automatic logic [31:0] maskable_bits(input int unsigned n, input int unsigned first);
      logic [31:0] m;
      m = '0;
      for (int i = 0; i < 32; i++)
         if (i >= first && i < n) m[i] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/irq_rst_filter.sv
module irq_rst_filter #(
   parameter int unsigned HOLD = 10
) (
   input  logic clk,
   input  logic por_n,
   input  logic line_n,
   output logic hit,
   output logic hold
);
   localparam int unsigned CW = $clog2(HOLD + 1);

   logic [CW-1:0] low_cnt;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                    low_cnt <= '0;
      else if (line_n)               low_cnt <= '0;
      else if (low_cnt != CW'(HOLD)) low_cnt <= low_cnt + 1'b1;
   end

   assign hit  = !line_n && (low_cnt == CW'(HOLD - 1));
   assign hold = !line_n && (low_cnt == CW'(HOLD));
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int unsigned N       = 16,
   parameter int unsigned FIRST   = 4,
   parameter int unsigned NMI_IDX = 1
) (
   input  logic         clk,
   input  logic         por_n,
   input  logic         wipe,
   input  logic         nmi_src,
   input  logic [N-FIRST-1:0] irq_src,
   input  logic [N-1:0] set_bits,
   input  logic [N-1:0] clr_bits,
   input  logic [N-1:0] take_clr,
   output logic [N-1:0] flags
);
   logic unused_low;
   assign unused_low = ^{set_bits[FIRST-1:0], clr_bits[FIRST-1:0], take_clr[FIRST-1:0]} ^ take_clr[NMI_IDX];

   for (genvar i = 0; i < N; i++) begin : g_bit
      if (i == NMI_IDX) begin : g_nmi
         logic prev, fl;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
               prev <= 1'b0;
               fl   <= 1'b0;
            end else begin
               prev <= nmi_src;
               if (wipe) fl <= 1'b0;
               else      fl <= (fl & ~take_clr[i]) | (nmi_src & ~prev);
            end
         end
         assign flags[i] = fl;
      end else if (i >= FIRST) begin : g_mask
         logic prev, fl;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
               prev <= 1'b0;
               fl   <= 1'b0;
            end else begin
               prev <= irq_src[i-FIRST];
               if (wipe) fl <= 1'b0;
               else      fl <= (fl & ~clr_bits[i] & ~take_clr[i])
                              | set_bits[i] | (irq_src[i-FIRST] & ~prev);
            end
         end
         assign flags[i] = fl;
      end else begin : g_none
         assign flags[i] = 1'b0;
      end
   end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
   parameter int unsigned N        = 16,
   parameter int unsigned FIRST    = 4,
   parameter int unsigned NMI_IDX  = 1,
   parameter bit          LOW_WINS = 1'b1,
   localparam int unsigned NW      = $clog2(N)
) (
   input  logic [N-1:0]  flags,
   input  logic [N-1:0]  ena,
   input  logic          gie,
   output logic          req,
   output logic [NW-1:0] num
);
   logic [N-1:0] ready;
   logic         nmi_ok;
   logic         mask_any;
   logic [NW-1:0] mask_num;

   assign nmi_ok = flags[NMI_IDX] & ena[NMI_IDX];

   for (genvar i = 0; i < N; i++) begin : g_ready
      if (i >= FIRST) begin : g_m
         assign ready[i] = flags[i] & ena[i] & gie & ena[NMI_IDX];
      end else begin : g_z
         assign ready[i] = 1'b0;
      end
   end

   if (LOW_WINS) begin : g_low
      always_comb begin
         mask_any = 1'b0;
         mask_num = '0;
         for (int i = N - 1; i >= int'(FIRST); i--)
            if (ready[i]) begin
               mask_any = 1'b1;
               mask_num = NW'(i);
            end
      end
   end else begin : g_high
      always_comb begin
         mask_any = 1'b0;
         mask_num = '0;
         for (int i = int'(FIRST); i < int'(N); i++)
            if (ready[i]) begin
               mask_any = 1'b1;
               mask_num = NW'(i);
            end
      end
   end

   assign req = nmi_ok | mask_any;
   assign num = nmi_ok ? NW'(NMI_IDX) : mask_num;
endmodule

// File: rtl/irq_prio_ctl.sv
module irq_prio_ctl #(
   parameter int unsigned NUM_LINES = 16,
   parameter int unsigned FIRST_MASK = 4,
   parameter int unsigned HOLD_CYCLES = 10,
   parameter bit          LOW_WINS = 1'b1,
   localparam int unsigned NW = $clog2(NUM_LINES),
   localparam int unsigned NM = NUM_LINES - FIRST_MASK
) (
   input  logic                 clk,
   input  logic                 por_n,
   input  logic                 rst_line_n,
   input  logic                 nmi_line,
   input  logic [NM-1:0]        irq_line,
   input  logic [NUM_LINES-1:0] set_bits,
   input  logic [NUM_LINES-1:0] clr_bits,
   input  logic                 ena_we,
   input  logic [NUM_LINES-1:0] ena_wdata,
   input  logic                 gie_we,
   input  logic                 gie_wdata,
   input  logic                 take_ack,
   output logic                 take_req,
   output logic [NW-1:0]        take_num,
   output logic                 iack,
   output logic [NW-1:0]        inum,
   output logic [NUM_LINES-1:0] flags_o,
   output logic [NUM_LINES-1:0] ena_o,
   output logic                 gie_o
);
   import irq_prio_pkg::*;

   localparam logic [31:0] MASK_ALL = maskable_bits(NUM_LINES, FIRST_MASK);
   localparam logic [NUM_LINES-1:0] ENA_KEEP =
      MASK_ALL[NUM_LINES-1:0] | (NUM_LINES'(1) << IDX_NMI);

   if (NUM_LINES < 8 || NUM_LINES > 32) begin : g_bad_lines
      initial $fatal(1, "NUM_LINES must lie in 8..32");
   end
   if (FIRST_MASK <= IDX_NMI || FIRST_MASK >= NUM_LINES) begin : g_bad_first
      initial $fatal(1, "FIRST_MASK must lie above the NMI index and below NUM_LINES");
   end
   if (HOLD_CYCLES < 2) begin : g_bad_hold
      initial $fatal(1, "HOLD_CYCLES must be at least 2");
   end

   logic rst_hit, rst_hold, wipe;
   logic pick_req;
   logic [NW-1:0] pick_num;
   logic take;
   logic [NUM_LINES-1:0] take_clr;
   logic [NUM_LINES-1:0] ena_q;
   logic gie_q;

   irq_rst_filter #(.HOLD(HOLD_CYCLES)) u_rst (
      .clk(clk), .por_n(por_n), .line_n(rst_line_n), .hit(rst_hit), .hold(rst_hold)
   );

   assign wipe = rst_hit | rst_hold;

   irq_flag_bank #(.N(NUM_LINES), .FIRST(FIRST_MASK), .NMI_IDX(IDX_NMI)) u_flags (
      .clk(clk), .por_n(por_n), .wipe(wipe), .nmi_src(nmi_line), .irq_src(irq_line),
      .set_bits(set_bits), .clr_bits(clr_bits), .take_clr(take_clr), .flags(flags_o)
   );

   irq_pick #(.N(NUM_LINES), .FIRST(FIRST_MASK), .NMI_IDX(IDX_NMI), .LOW_WINS(LOW_WINS)) u_pick (
      .flags(flags_o), .ena(ena_q), .gie(gie_q), .req(pick_req), .num(pick_num)
   );

   assign take_req = pick_req & ~wipe;
   assign take_num = pick_num;
   assign take     = take_req & take_ack;
   assign take_clr = take ? (NUM_LINES'(1) << pick_num) : '0;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         ena_q <= '0;
         gie_q <= 1'b0;
         iack  <= 1'b0;
         inum  <= '0;
      end else if (wipe) begin
         ena_q <= '0;
         gie_q <= 1'b0;
         iack  <= rst_hit;
         inum  <= NW'(IDX_RESET);
      end else begin
         iack <= take;
         inum <= take ? pick_num : '0;
         if (ena_we) ena_q <= ena_wdata & ENA_KEEP;
         if (take && pick_num == NW'(IDX_NMI)) ena_q[IDX_NMI] <= 1'b0;
         if (gie_we) gie_q <= gie_wdata;
         if (take)   gie_q <= 1'b0;
      end
   end

   assign ena_o = ena_q;
   assign gie_o = gie_q;
endmodule

// File: rtl/irq_prio_ctl_chk.sv
module irq_prio_ctl_chk #(
   parameter int unsigned NUM_LINES = 16,
   parameter int unsigned NW = 4
) (
   input logic                 clk,
   input logic                 por_n,
   input logic                 take_ack,
   input logic                 take_req,
   input logic [NW-1:0]        take_num,
   input logic                 iack,
   input logic [NW-1:0]        inum,
   input logic [NUM_LINES-1:0] flags_o,
   input logic [NUM_LINES-1:0] ena_o,
   input logic                 gie_o
);
   a_r5_mask_all_four: assert property (@(posedge clk) disable iff (!por_n)
      (take_req && take_num != NW'(1)) |-> (gie_o && ena_o[1] && ena_o[take_num] && flags_o[take_num]));

   a_r7_nmi_first: assert property (@(posedge clk) disable iff (!por_n)
      (take_req && flags_o[1] && ena_o[1]) |-> (take_num == NW'(1)));

   a_r8_ack_number: assert property (@(posedge clk) disable iff (!por_n)
      (take_req && take_ack) |=> (iack && inum == $past(take_num)));

   a_r8_gie_cleared: assert property (@(posedge clk) disable iff (!por_n)
      (take_req && take_ack) |=> !gie_o);

   a_r8_nmie_cleared: assert property (@(posedge clk) disable iff (!por_n)
      (take_req && take_ack && take_num == NW'(1)) |=> !ena_o[1]);

   a_r9_reset_defaults: assert property (@(posedge clk) disable iff (!por_n)
      (iack && inum == '0) |-> (flags_o == '0 && ena_o == '0 && !gie_o));

   a_r10_ack_needs_take: assert property (@(posedge clk) disable iff (!por_n)
      (iack && inum != '0) |-> $past(take_req && take_ack));
endmodule

bind irq_prio_ctl irq_prio_ctl_chk #(.NUM_LINES(NUM_LINES), .NW(NW)) u_chk (
   .clk(clk), .por_n(por_n), .take_ack(take_ack), .take_req(take_req), .take_num(take_num),
   .iack(iack), .inum(inum), .flags_o(flags_o), .ena_o(ena_o), .gie_o(gie_o)
);

// File: tb/irq_prio_ctl_tb.sv
module irq_prio_ctl_tb;
   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        rst_line_n = 1'b1;
   logic        nmi_line = 1'b0;
   logic [11:0] irq_line = '0;
   logic [15:0] set_bits = '0, clr_bits = '0, ena_wdata = '0;
   logic        ena_we = 1'b0, gie_we = 1'b0, gie_wdata = 1'b0, take_ack = 1'b0;
   logic        take_req, iack, gie_o;
   logic [3:0]  take_num, inum;
   logic [15:0] flags_o, ena_o;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   irq_prio_ctl u_dut (
      .clk(clk), .por_n(por_n), .rst_line_n(rst_line_n), .nmi_line(nmi_line), .irq_line(irq_line),
      .set_bits(set_bits), .clr_bits(clr_bits), .ena_we(ena_we), .ena_wdata(ena_wdata),
      .gie_we(gie_we), .gie_wdata(gie_wdata), .take_ack(take_ack), .take_req(take_req),
      .take_num(take_num), .iack(iack), .inum(inum), .flags_o(flags_o), .ena_o(ena_o), .gie_o(gie_o)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic clean();
      clr_bits = 16'hFFFF; ena_we = 1'b1; ena_wdata = '0; gie_we = 1'b1; gie_wdata = 1'b0;
      step();
      clr_bits = '0; ena_we = 1'b0; gie_we = 1'b0;
   endtask

   task automatic setup(input logic [15:0] fl, input logic [15:0] en, input logic g);
      set_bits = fl; ena_we = 1'b1; ena_wdata = en; gie_we = 1'b1; gie_wdata = g;
      step();
      set_bits = '0; ena_we = 1'b0; gie_we = 1'b0;
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] lf;
      logic [15:0] fl, en, m;
      int          expn;
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      step();
      // R1 reset state
      check("R1 flags", flags_o, 0);
      check("R1 ena", ena_o, 0);
      check("R1 gie", gie_o, 0);
      check("R1 req", take_req, 0);
      check("R1 iack", iack, 0);

      // R3 write-one set and clear, low bits ignored
      set_bits = 16'hFFFF; step(); set_bits = '0;
      check("R3 set all", flags_o, 16'hFFF0);
      clr_bits = 16'h00F0; step(); clr_bits = '0;
      check("R3 clear some", flags_o, 16'hFF00);
      step();
      check("R3 zeros no effect", flags_o, 16'hFF00);
      clr_bits = 16'hFFFF; step(); clr_bits = '0;
      check("R3 clear all", flags_o, 0);

      // R2 NMI edge; R3 cannot clear NMI flag
      nmi_line = 1'b1; step();
      check("R2 nmi edge", flags_o, 16'h0002);
      clr_bits = 16'hFFFF; step(); clr_bits = '0;
      check("R3 nmi untouched by clear", flags_o, 16'h0002);
      check("R7 no req without nmie", take_req, 0);
      nmi_line = 1'b0;

      // R7 NMI needs only its enable and beats maskable
      setup(16'h0010, 16'h0012, 1'b0);
      check("R7 nmi req gie0", {take_req, take_num}, {1'b1, 4'd1});
      gie_we = 1'b1; gie_wdata = 1'b1; step(); gie_we = 1'b0;
      check("R7 nmi beats int4", {take_req, take_num}, {1'b1, 4'd1});
      take_ack = 1'b1; step(); take_ack = 1'b0;
      check("R8 nmi iack", {iack, inum}, {1'b1, 4'd1});
      check("R8 nmi flag cleared", flags_o, 16'h0010);
      check("R8 nmie cleared", ena_o, 16'h0010);
      check("R8 gie cleared", gie_o, 0);
      step();
      check("R8 iack one cycle", iack, 0);
      clean();

      // R2 sweep of maskable line edges
      for (int k = 0; k < 12; k++) begin
         irq_line[k] = 1'b1; step();
         check("R2 edge sets flag", flags_o, 32'(16'h1 << (k + 4)));
         clr_bits = 16'h1 << (k + 4); step(); clr_bits = '0;
         step();
         check("R2 level does not re-set", flags_o, 0);
         irq_line[k] = 1'b0; step();
      end

      // R4 set wins over clear
      set_bits = 16'h0080; clr_bits = 16'h0080; step(); set_bits = '0; clr_bits = '0;
      check("R4 set wins", flags_o, 16'h0080);
      clean();

      // R5 all sixteen combinations of the four conditions on INT9
      for (int c = 0; c < 16; c++) begin
         setup(c[3] ? 16'h0200 : 16'h0, (c[2] ? 16'h0200 : 16'h0) | (c[1] ? 16'h0002 : 16'h0), c[0]);
         check("R5 condition req", take_req, (c == 15) ? 1 : 0);
         if (c == 15) check("R5 condition num", take_num, 9);
         clean();
      end

      // R6 lowest wins, R8 take effects, over pseudo-random patterns
      lf = 16'hACE1;
      for (int it = 0; it < 40; it++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         fl = lf & 16'hFFF0;
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         en = (lf & 16'hFFF0) | 16'h0002;
         m = fl & en;
         expn = -1;
         for (int b = 15; b >= 4; b--) if (m[b]) expn = b;
         setup(fl, en, 1'b1);
         check("R6 req", take_req, (expn >= 0) ? 1 : 0);
         if (expn >= 0) begin
            check("R6 lowest num", take_num, expn);
            take_ack = 1'b1; step(); take_ack = 1'b0;
            check("R8 iack num", {iack, inum}, {1'b1, 4'(expn)});
            check("R8 flag cleared", flags_o, fl & ~(16'h1 << expn));
            check("R8 gie cleared", gie_o, 0);
            check("R8 nmie kept", ena_o[1], 1);
         end
         clean();
      end

      // R10 acknowledge with nothing pending
      setup(16'h0400, 16'h0000, 1'b1);
      take_ack = 1'b1; step(); take_ack = 1'b0;
      check("R10 no iack", iack, 0);
      check("R10 flag kept", flags_o, 16'h0400);
      clean();

      // R9 short reset pulse ignored
      setup(16'h8010, 16'h8012, 1'b1);
      rst_line_n = 1'b0;
      for (int i = 0; i < 9; i++) begin
         step();
         check("R9 short pulse no iack", iack, 0);
      end
      rst_line_n = 1'b1; step();
      check("R9 short pulse flags kept", flags_o, 16'h8010);
      check("R9 short pulse ena kept", ena_o, 16'h8012);
      check("R9 short pulse gie kept", gie_o, 1);

      // R9 full reset pulse
      rst_line_n = 1'b0;
      repeat (10) step();
      check("R9 reset iack", {iack, inum}, {1'b1, 4'd0});
      check("R9 reset flags", flags_o, 0);
      check("R9 reset ena", ena_o, 0);
      check("R9 reset gie", gie_o, 0);
      step();
      check("R9 reset iack single", iack, 0);
      rst_line_n = 1'b1; step();
      check("R9 after release idle", take_req, 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule